// File: doc/BRIEF.md
# Configurable Noise LFSR Generator

This block is the noise voice of a programmable sound generator. A right-shifting linear feedback shift register produces a pseudo-random bit stream when white noise is selected. When periodic noise is selected, it produces a short repeating pattern. A down-counter driven by an external tick strobe sets how often the register shifts. The rate comes either from one of three fixed periods or from twice the period currently programmed into the third tone channel.

Elaboration parameters set the register width, the single-bit position where feedback is inserted, the two tap masks, and the feedback polarity (XOR or XNOR). They also set how control writes reload the register. In one variant every write reloads it. In the other, a write reloads it only when the noise-mode bit changes. Software-facing logic writes a 3-bit control value with a one-cycle strobe. The block reads the tone-2 period directly from the tone channel. The single output is the current noise bit, which the mixer scales.

Top module: `noise_lfsr_gen`

## Requirements
- R1: An active-low reset loads the LFSR with the feedback mask, clears the shift counter and clears the stored control to periodic mode at rate code 0. With the default mask 0x8000, noise_o is 0 after reset.
- R2: Control bits [1:0] select the shift period. Code 0 gives 32 ticks, code 1 gives 64 ticks and code 2 gives 128 ticks. For a first shift on the first tick after reset or reload of the counter, the shift number n falls on tick 1+P*(n-1).
- R3: Rate code 3 uses twice the value on tone2_period_i. That input is read whenever the counter reloads, so a change to the tone-2 period takes effect without a new control write.
- R4: Control bit 2 set selects white noise. In the default configuration the feedback is the XOR of LFSR bit 0 and bit 3.
- R5: Control bit 2 clear selects periodic noise. Tap 2 is forced to its neutral value, so the feedback equals the tap-1 bit. With the default configuration a single 1 circulates through 16 positions.
- R6: On a shift the LFSR moves right by one place, and a feedback value of 1 is ORed into the feedback-mask position.
- R7: noise_o is bit 0 of the LFSR. It changes only on a shift or a reload.
- R8: In the default variant, every control write reloads the LFSR with the feedback mask, even if the mode bit is unchanged. A reload takes priority over a shift in the same cycle.
- R9: With RELOAD_ON_CHANGE set, a control write reloads the LFSR only when ctl_i[2] differs from the stored mode bit. The write still updates the stored rate and mode.
- R10: On each tick the counter does one of two things. If it holds 0 or 1, it triggers a shift and loads the selected period. Otherwise it decrements by one. Without a tick it holds its value. A selected period of 0 therefore shifts on every tick.
- R11: With USE_XNOR set, white-noise feedback is the XNOR of the two taps. An example is a 15-bit register with mask 0x4000 and taps on bits 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Shift-rate tick strobe, one cycle per tick |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_i | input | 3 | Control value: bit 2 selects white noise, bits [1:0] select the rate |
| tone2_period_i | input | PER_W | Current period of tone channel 2 |
| noise_o | output | 1 | Current noise bit |

## Verification
The assertions assume that tick_i and ctl_we_i are single-cycle strobes sampled at the clock edge. They also assume that tone2_period_i is stable around each edge. Any overlap of a write and a tick is legal and must resolve with the reload taking priority. The stimulus drives every input one nanosecond after the rising edge and holds it for the whole cycle. Ticks arrive in a two-of-three pattern during the table walk and on every cycle in the directed tests. Writes that coincide with an expiring tick are included on purpose, and so are tone-2 period changes while the tone-derived rate is active.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

   typedef enum logic [1:0] {
      RATE_DIV32  = 2'd0,
      RATE_DIV64  = 2'd1,
      RATE_DIV128 = 2'd2,
      RATE_TONE2  = 2'd3
   } rate_e;

   typedef struct packed {
      logic  white;
      rate_e rate;
   } noise_ctl_t;

   localparam int unsigned BASE_LOG2 = 5;

   function automatic int unsigned fixed_period(input rate_e r);
      return 32'd1 << (BASE_LOG2 + int'(r));
   endfunction

endpackage

// File: rtl/noise_rate_sel.sv
module noise_rate_sel
   import noise_lfsr_pkg::*;
#(
   parameter int unsigned PER_W = 10,
   parameter int unsigned CNT_W = PER_W + 1
) (
   input  rate_e             rate_i,
   input  logic [PER_W-1:0]  tone2_i,
   output logic [CNT_W-1:0]  period_o
);

   localparam int unsigned MIN_W = BASE_LOG2 + 3;

   if (CNT_W < PER_W + 1) begin : g_bad_cnt_w
      $error("noise_rate_sel: CNT_W must hold twice the tone period");
   end
   if (CNT_W < MIN_W) begin : g_bad_fixed_w
      $error("noise_rate_sel: CNT_W too narrow for the fixed periods");
   end

   logic [PER_W:0] tone_dbl;
   assign tone_dbl = {tone2_i, 1'b0};

   always_comb begin
      unique case (rate_i)
         RATE_TONE2: period_o = CNT_W'(tone_dbl);
         default:    period_o = CNT_W'(fixed_period(rate_i));
      endcase
   end

endmodule

// File: rtl/noise_shift_timer.sv
module noise_shift_timer #(
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             shift_o
);

   if (CNT_W < 2) begin : g_bad_w
      $error("noise_shift_timer: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             expire;

   assign expire  = tick_i && (cnt_q <= CNT_W'(1));
   assign shift_o = expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (expire) begin
         cnt_q <= period_i;
      end else if (tick_i) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q));

   p_reload_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_o |=> (cnt_q == $past(period_i)));

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core #(
   parameter int unsigned    LW               = 16,
   parameter logic [LW-1:0]  FB_MASK          = 16'h8000,
   parameter logic [LW-1:0]  TAP1             = 16'h0001,
   parameter logic [LW-1:0]  TAP2             = 16'h0008,
   parameter bit             USE_XNOR         = 1'b0,
   parameter bit             RELOAD_ON_CHANGE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_i,
   input  logic          ctl_we_i,
   input  logic          mode_wr_i,
   input  logic          mode_cur_i,
   output logic [LW-1:0] state_o
);

   if (LW < 4) begin : g_bad_lw
      $error("noise_lfsr_core: LW must be at least 4");
   end
   if (FB_MASK == '0 || (FB_MASK & (FB_MASK - LW'(1))) != '0) begin : g_bad_fb
      $error("noise_lfsr_core: FB_MASK must have exactly one bit set");
   end
   if (TAP1 == '0 || TAP2 == '0) begin : g_bad_tap
      $error("noise_lfsr_core: tap masks must be non-zero");
   end

   logic [LW-1:0] state_q;
   logic          tap1_bit;
   logic          tap2_bit;
   logic          fb;
   logic          reload;

   assign tap1_bit = |(state_q & TAP1);
   assign tap2_bit = |(state_q & TAP2);

   if (RELOAD_ON_CHANGE) begin : g_reload_on_change
      assign reload = ctl_we_i && (mode_wr_i != mode_cur_i);
   end else begin : g_reload_every_write
      assign reload = ctl_we_i;
   end

   if (USE_XNOR) begin : g_fb_xnor
      logic tap2_eff;
      assign tap2_eff = mode_cur_i ? tap2_bit : 1'b1;
      assign fb       = ~(tap1_bit ^ tap2_eff);
   end else begin : g_fb_xor
      logic tap2_eff;
      assign tap2_eff = mode_cur_i ? tap2_bit : 1'b0;
      assign fb       = tap1_bit ^ tap2_eff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FB_MASK;
      end else if (reload) begin
         state_q <= FB_MASK;
      end else if (shift_i) begin
         state_q <= (state_q >> 1) | (fb ? FB_MASK : '0);
      end
   end

   assign state_o = state_q;

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_i && !ctl_we_i) |=> $stable(state_q));

   p_shift_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !reload) |=>
         ((state_q & ~FB_MASK) == (($past(state_q) >> 1) & ~FB_MASK)));

   p_reload_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (state_q == FB_MASK));

   p_periodic_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !reload && !mode_cur_i) |=>
         ((|(state_q & FB_MASK)) == (|($past(state_q) & TAP1))));

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
   import noise_lfsr_pkg::*;
#(
   parameter int unsigned        LFSR_W           = 16,
   parameter logic [LFSR_W-1:0]  FB_MASK          = 16'h8000,
   parameter logic [LFSR_W-1:0]  TAP1             = 16'h0001,
   parameter logic [LFSR_W-1:0]  TAP2             = 16'h0008,
   parameter bit                 USE_XNOR         = 1'b0,
   parameter bit                 RELOAD_ON_CHANGE = 1'b0,
   parameter int unsigned        PER_W            = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ctl_we_i,
   input  logic [2:0]       ctl_i,
   input  logic [PER_W-1:0] tone2_period_i,
   output logic             noise_o
);

   localparam int unsigned CNT_W = (PER_W + 1 > BASE_LOG2 + 3) ? PER_W + 1 : BASE_LOG2 + 3;

   noise_ctl_t        ctl_q;
   logic [CNT_W-1:0]  period;
   logic              shift_stb;
   logic [LFSR_W-1:0] lfsr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_we_i) begin
         ctl_q <= noise_ctl_t'(ctl_i);
      end
   end

   noise_rate_sel #(
      .PER_W (PER_W),
      .CNT_W (CNT_W)
   ) i_rate_sel (
      .rate_i   (ctl_q.rate),
      .tone2_i  (tone2_period_i),
      .period_o (period)
   );

   noise_shift_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .period_i (period),
      .shift_o  (shift_stb)
   );

   noise_lfsr_core #(
      .LW               (LFSR_W),
      .FB_MASK          (FB_MASK),
      .TAP1             (TAP1),
      .TAP2             (TAP2),
      .USE_XNOR         (USE_XNOR),
      .RELOAD_ON_CHANGE (RELOAD_ON_CHANGE)
   ) i_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_i    (shift_stb),
      .ctl_we_i   (ctl_we_i),
      .mode_wr_i  (ctl_i[2]),
      .mode_cur_i (ctl_q.white),
      .state_o    (lfsr)
   );

   assign noise_o = lfsr[0];

   p_fixed_pow2_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.rate != RATE_TONE2) |-> ($countones(period) == 1));

   p_noise_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_stb && !ctl_we_i) |=> $stable(noise_o));

   p_ctl_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we_i |=> (ctl_q == $past(ctl_i)));

endmodule

// File: tb/test_noise_lfsr_gen.sv
`timescale 1ns/1ps
module test_noise_lfsr_gen;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic       we;
   logic [2:0] ctl;
   logic [9:0] tone2;
   logic       noise_m;
   logic       noise_a;

   always #4 clk = ~clk;

   noise_lfsr_gen i_noise_lfsr_gen (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_i         (tick),
      .ctl_we_i       (we),
      .ctl_i          (ctl),
      .tone2_period_i (tone2),
      .noise_o        (noise_m)
   );

   noise_lfsr_gen #(
      .LFSR_W           (15),
      .FB_MASK          (15'h4000),
      .TAP1             (15'h0001),
      .TAP2             (15'h0010),
      .USE_XNOR         (1'b1),
      .RELOAD_ON_CHANGE (1'b1),
      .PER_W            (10)
   ) i_noise_lfsr_gen_alt (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_i         (tick),
      .ctl_we_i       (we),
      .ctl_i          (ctl),
      .tone2_period_i (tone2),
      .noise_o        (noise_a)
   );

   int checks   = 0;
   int failures = 0;
   int seg_err;

   logic [15:0] m_lfsr;
   logic [14:0] a_lfsr;
   int          m_cnt;
   logic [2:0]  m_ctl;

   function automatic int exp_period(input logic [2:0] c, input logic [9:0] t);
      case (c[1:0])
         2'd0:    return 32;
         2'd1:    return 64;
         2'd2:    return 128;
         default: return 2 * int'(t);
      endcase
   endfunction

   function automatic logic [15:0] main_shift(input logic [15:0] s, input logic white);
      logic fb;
      fb = s[0] ^ (white ? s[3] : 1'b0);
      return {fb, s[15:1]};
   endfunction

   function automatic logic [14:0] alt_shift(input logic [14:0] s, input logic white);
      logic fb;
      fb = white ? ~(s[0] ^ s[4]) : s[0];
      return {fb, s[14:1]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic step(input logic w, input logic [2:0] c, input logic tk);
      int          per;
      bit          expire;
      int          ncnt;
      logic [15:0] nm;
      logic [14:0] na;
      per    = exp_period(m_ctl, tone2);
      expire = tk && (m_cnt <= 1);
      ncnt   = !tk ? m_cnt : (expire ? per : m_cnt - 1);
      nm     = w ? 16'h8000 : (expire ? main_shift(m_lfsr, m_ctl[2]) : m_lfsr);
      na     = (w && (c[2] != m_ctl[2])) ? 15'h4000
             : (expire ? alt_shift(a_lfsr, m_ctl[2]) : a_lfsr);
      we   = w;
      ctl  = c;
      tick = tk;
      @(posedge clk);
      #1;
      m_lfsr = nm;
      a_lfsr = na;
      m_cnt  = ncnt;
      if (w) m_ctl = c;
      we   = 1'b0;
      tick = 1'b0;
      if (noise_m !== m_lfsr[0] || noise_a !== a_lfsr[0]) seg_err++;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      we    = 1'b0;
      tick  = 1'b0;
      ctl   = 3'b000;
      repeat (3) @(posedge clk);
      #1;
      rst_n  = 1'b1;
      m_lfsr = 16'h8000;
      a_lfsr = 15'h4000;
      m_cnt  = 0;
      m_ctl  = 3'b000;
   endtask

   task automatic count_rise(input int limit, output int n_m, output int n_a);
      n_m = -1;
      n_a = -1;
      for (int k = 1; k <= limit; k++) begin
         step(1'b0, m_ctl, 1'b1);
         if (noise_m && n_m < 0) n_m = k;
         if (noise_a && n_a < 0) n_a = k;
      end
   endtask

   // {ctl[2:0], tone2[9:0], cycles[15:0]}
   localparam logic [28:0] VEC [8] = '{
      {3'b100, 10'd0, 16'd500},
      {3'b101, 10'd0, 16'd900},
      {3'b110, 10'd0, 16'd1500},
      {3'b111, 10'd5, 16'd400},
      {3'b011, 10'd3, 16'd300},
      {3'b001, 10'd0, 16'd800},
      {3'b111, 10'd0, 16'd200},
      {3'b111, 10'd0, 16'd100}
   };

   string vec_req [8] = '{"R2 R4", "R2 R4", "R2 R6", "R3 R4", "R3 R5",
                          "R2 R5", "R10 R11", "R8 R9"};

   initial begin
      #2_000_000;
      failures++;
      checks++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int nm;
      int na;
      logic hm [64];
      logic ha [64];
      rst_n = 1'b0;
      we    = 1'b0;
      tick  = 1'b0;
      ctl   = 3'b000;
      tone2 = 10'd0;
      seg_err = 0;
      do_reset();

      // R1: reset state at the output
      check(noise_m == 1'b0, "R1", "main noise after reset", noise_m, 0);
      check(noise_a == 1'b0, "R1", "alt noise after reset", noise_a, 0);

      // table walk, compared each cycle against the requirement model
      for (int i = 0; i < 8; i++) begin
         tone2   = VEC[i][25:16];
         seg_err = 0;
         step(1'b1, VEC[i][28:26], 1'b0);
         for (int k = 0; k < int'(VEC[i][15:0]); k++)
            step(1'b0, VEC[i][28:26], (k % 3) != 2);
         check(seg_err == 0, vec_req[i], $sformatf("vector %0d mismatching cycles", i),
               seg_err, 0);
      end

      // R1: mid-run reset restores the initial state
      step(1'b0, m_ctl, 1'b1);
      do_reset();
      check(noise_m == 1'b0 && noise_a == 1'b0, "R1", "noise after mid-run reset",
            {noise_m, noise_a}, 0);

      // R1 R5 R2: stored control after reset is periodic /32
      seg_err = 0;
      count_rise(460, nm, na);
      check(nm == 449, "R1 R5", "main ticks to first 1, default control", nm, 449);
      check(na == 417, "R2 R5", "alt ticks to first 1, default control", na, 417);

      // R2: rate code 1 and 2
      do_reset();
      step(1'b1, 3'b001, 1'b0);
      count_rise(900, nm, na);
      check(nm == 897, "R2", "ticks to first 1 at rate code 1", nm, 897);
      do_reset();
      step(1'b1, 3'b010, 1'b0);
      count_rise(1800, nm, na);
      check(nm == 1793, "R2", "ticks to first 1 at rate code 2", nm, 1793);

      // R3: tone-derived period, then live change of the tone period
      do_reset();
      tone2 = 10'd4;
      step(1'b1, 3'b011, 1'b0);
      count_rise(120, nm, na);
      check(nm == 113, "R3", "ticks to first 1 with tone2 period 4", nm, 113);
      seg_err = 0;
      step(1'b1, 3'b111, 1'b0);
      for (int k = 0; k < 60; k++) step(1'b0, m_ctl, 1'b1);
      tone2 = 10'd9;
      for (int k = 0; k < 150; k++) step(1'b0, m_ctl, 1'b1);
      check(seg_err == 0, "R3", "mismatches after tone2 change", seg_err, 0);

      // R10 R4 R6 R7 R11: period 0, one shift per tick, bit history
      do_reset();
      tone2 = 10'd0;
      step(1'b1, 3'b111, 1'b0);
      for (int k = 1; k < 40; k++) begin
         step(1'b0, m_ctl, 1'b1);
         hm[k] = noise_m;
         ha[k] = noise_a;
      end
      check(hm[14] == 1'b0 && hm[15] == 1'b1, "R10 R7", "main bit at ticks 14/15",
            {hm[14], hm[15]}, 1);
      check(hm[28] == 1'b1, "R4", "main white feedback bit at tick 28", hm[28], 1);
      check(hm[16] == 1'b0, "R6", "main bit at tick 16", hm[16], 0);
      check(ha[13] == 1'b0 && ha[14] == 1'b1, "R10 R6", "alt bit at ticks 13/14",
            {ha[13], ha[14]}, 1);
      check(ha[15] == 1'b1, "R11", "alt XNOR feedback bit at tick 15", ha[15], 1);

      // R8: same-mode rewrite reloads main; R9: alt keeps its state
      seg_err = 0;
      step(1'b1, 3'b111, 1'b0);
      check(seg_err == 0, "R9", "alt unchanged on same-mode write", seg_err, 0);
      count_rise(20, nm, na);
      check(nm == 15, "R8", "main ticks to first 1 after rewrite", nm, 15);
      step(1'b1, 3'b011, 1'b0);
      count_rise(20, nm, na);
      check(na == 14, "R9", "alt ticks to first 1 after mode change", na, 14);
      check(nm == 15, "R5", "main periodic ticks to first 1", nm, 15);

      // R8 R10: write and expiring tick in the same cycle, reload wins
      do_reset();
      step(1'b1, 3'b100, 1'b1);
      count_rise(500, nm, na);
      check(nm == 480, "R8 R10", "ticks to first 1 after write with tick", nm, 480);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule